// File: doc/BRIEF.md
# Codec Control-Port Serial Writer

This block writes a single configuration register inside one or more audio codecs over a three-wire control port. The three wires are a control clock, a serial data line and one chip select per codec. A request carries three fields: a codec select mask, a register index and a data byte. The block first checks the request. It then builds a 16-bit command word, asserts the chip select of every selected codec and shifts the word out most significant bit first. Each codec samples the data line on the rising edge of the control clock. At the end of the frame the block releases the chip selects, returns the clock and data lines to their high idle level, and reports completion with a one-cycle pulse.

A request arrives over a valid/ready handshake. A request whose mask names a codec that does not exist, or whose register index is out of range, is refused with a one-cycle error pulse, and nothing is sent. Several codecs can take the same frame at once when more than one mask bit is set. The control clock runs at a fraction of the system clock. A parameter sets how many system cycles make up each half period.

Top module: `codec_ctl_writer`

## Requirements
- R1: After reset, ctl_clk and ctl_data are 1, every ctl_cs bit is 1 (deasserted), busy, done and err are 0, and req_ready is 1.
- R2: The shifted command word is {2'b10, 1'b1, req_index[4:0], req_data[7:0]}: chip address in bits 15:14, the write flag in bit 13, the register index in bits 12:8 and the data in bits 7:0.
- R3: Each frame carries exactly 16 bits, most significant first, one bit per rising edge of ctl_clk while a chip select is asserted.
- R4: ctl_data changes only while ctl_clk is low. It holds its value on every cycle that ctl_clk is high with a codec selected, including the cycle of the rising edge.
- R5: The frame opens with one half period in which ctl_clk and ctl_data are 0 and no chip select is asserted. After that, ctl_cs[k] is driven to 0 for the whole frame exactly when mask bit k is 1, for k in 0..2.
- R6: A request with req_mask above 7 (bit 3 set) or req_index above 7 is refused. In the cycle after acceptance err is 1 for one cycle, busy stays 0, no chip select is asserted and the lines stay high.
- R7: After the high phase of the last bit, ctl_clk stays low for one half period with the chip selects still asserted. Then for one half period ctl_clk stays low with all chip selects released. After that ctl_clk and ctl_data are driven high.
- R8: During a frame each high and low level of ctl_clk lasts HALF_DIV system cycles, and busy stays high for 35*HALF_DIV cycles.
- R9: req_ready is 1 only while the block is idle. A request is taken on a clock edge where req_valid and req_ready are both 1. A request presented while the block is busy waits until it becomes idle.
- R10: done is a single-cycle pulse in the cycle where busy falls, with the lines already idle. req_ready returns one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mask | input | 4 | Codec select mask, one bit per codec; bit 3 is illegal |
| req_index | input | 5 | Register index, legal range 0..7 |
| req_data | input | 8 | Register value |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame has finished |
| err | output | 1 | One-cycle pulse when a request is refused |
| ctl_clk | output | 1 | Control port clock, idle high |
| ctl_data | output | 1 | Control port serial data, idle high |
| ctl_cs | output | 3 | Per-codec chip selects, active low |

## Verification
The bound checker watches several rules on every cycle: data stability while the control clock is high, the low setup phase before a chip select is asserted, the clock being low when the selects are released, the length of each high phase, and the shape of the done and error pulses. Some things only the bench scenarios can show: the bit content and order of the word for several masks, indices and data values, both kinds of refused request, a mask of zero, and a request held during a busy frame. The bench's per-cycle reference model also confirms the exact length of each phase and the cycle in which a waiting request is taken.

// File: rtl/ccw_pkg.sv
package ccw_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PREP,
      PH_LOW,
      PH_HIGH,
      PH_TAIL,
      PH_REL,
      PH_DONE,
      PH_ERR
   } ccw_phase_e;

   function automatic logic phase_is_busy(ccw_phase_e ph);
      return (ph == PH_PREP) || (ph == PH_LOW) || (ph == PH_HIGH) ||
             (ph == PH_TAIL) || (ph == PH_REL);
   endfunction

   function automatic logic phase_lines_idle(ccw_phase_e ph);
      return (ph == PH_IDLE) || (ph == PH_DONE) || (ph == PH_ERR);
   endfunction

endpackage

// File: rtl/ccw_req_check.sv
module ccw_req_check #(
   parameter int NUM_CS  = 3,
   parameter int MASK_W  = 4,
   parameter int IDX_W   = 5,
   parameter int DATA_W  = 8,
   parameter int MAX_IDX = 7,
   parameter int ADDR_W  = 2,
   parameter logic [ADDR_W-1:0] CHIP_ADDR = 2'b10,
   localparam int CMD_W  = ADDR_W + 1 + IDX_W + DATA_W
) (
   input  logic [MASK_W-1:0] mask,
   input  logic [IDX_W-1:0]  index,
   input  logic [DATA_W-1:0] data,
   output logic              ok,
   output logic [NUM_CS-1:0] sel_mask,
   output logic [CMD_W-1:0]  word
);

   logic mask_ok;
   logic idx_ok;

   generate
      if (MASK_W > NUM_CS) begin : g_wide_mask
         assign mask_ok = ~|mask[MASK_W-1:NUM_CS];
      end else begin : g_exact_mask
         assign mask_ok = 1'b1;
      end
   endgenerate

   assign sel_mask = mask[NUM_CS-1:0];
   assign idx_ok   = (int'(index) <= MAX_IDX);
   assign ok       = mask_ok && idx_ok;
   assign word     = {CHIP_ADDR, 1'b1, index, data};

endmodule

// File: rtl/ccw_half_timer.sv
module ccw_half_timer #(
   parameter int HALF_DIV = 4,
   localparam int CNT_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ccw_shifter.sv
module ccw_shifter #(
   parameter int CMD_W   = 16,
   localparam int BCNT_W = $clog2(CMD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CMD_W-1:0] word_in,
   input  logic             shift,
   output logic             msb,
   output logic             last
);

   logic [CMD_W-1:0]  sreg_q;
   logic [BCNT_W-1:0] left_q;

   assign msb  = sreg_q[CMD_W-1];
   assign last = (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         left_q <= '0;
      end else if (load) begin
         sreg_q <= word_in;
         left_q <= BCNT_W'(CMD_W - 1);
      end else if (shift) begin
         sreg_q <= {sreg_q[CMD_W-2:0], 1'b0};
         left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/ccw_cs_drive.sv
module ccw_cs_drive #(
   parameter int NUM_CS        = 3,
   parameter bit CS_ACTIVE_LOW = 1'b1
) (
   input  logic [NUM_CS-1:0] sel,
   input  logic              enable,
   output logic [NUM_CS-1:0] cs
);

   generate
      if (CS_ACTIVE_LOW) begin : g_low
         assign cs = enable ? ~sel : {NUM_CS{1'b1}};
      end else begin : g_high
         assign cs = enable ? sel : {NUM_CS{1'b0}};
      end
   endgenerate

endmodule

// File: rtl/codec_ctl_writer.sv
module codec_ctl_writer
   import ccw_pkg::*;
#(
   parameter int NUM_CS   = 3,
   parameter int MASK_W   = 4,
   parameter int IDX_W    = 5,
   parameter int DATA_W   = 8,
   parameter int MAX_IDX  = 7,
   parameter int ADDR_W   = 2,
   parameter logic [ADDR_W-1:0] CHIP_ADDR = 2'b10,
   parameter int HALF_DIV = 4,
   parameter bit CS_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [MASK_W-1:0] req_mask,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              ctl_clk,
   output logic              ctl_data,
   output logic [NUM_CS-1:0] ctl_cs
);

   localparam int CMD_W = ADDR_W + 1 + IDX_W + DATA_W;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (MASK_W < NUM_CS) begin : g_bad_mask
         $error("MASK_W must cover NUM_CS");
      end
      if (MAX_IDX >= (1 << IDX_W)) begin : g_bad_idx
         $error("MAX_IDX must fit in IDX_W bits");
      end
      if (CMD_W < 2) begin : g_bad_cmd
         $error("command word too short");
      end
   endgenerate

   ccw_phase_e        phase_q, phase_d;
   logic              accept;
   logic              req_ok;
   logic [NUM_CS-1:0] sel_mask;
   logic [NUM_CS-1:0] mask_q;
   logic [CMD_W-1:0]  word;
   logic              run;
   logic              tick;
   logic              msb;
   logic              last;
   logic              load;
   logic              shift_en;
   logic              cs_en;
   logic              lines_idle;

   ccw_req_check #(
      .NUM_CS    (NUM_CS),
      .MASK_W    (MASK_W),
      .IDX_W     (IDX_W),
      .DATA_W    (DATA_W),
      .MAX_IDX   (MAX_IDX),
      .ADDR_W    (ADDR_W),
      .CHIP_ADDR (CHIP_ADDR)
   ) u_check (
      .mask     (req_mask),
      .index    (req_index),
      .data     (req_data),
      .ok       (req_ok),
      .sel_mask (sel_mask),
      .word     (word)
   );

   ccw_half_timer #(
      .HALF_DIV (HALF_DIV)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   ccw_shifter #(
      .CMD_W (CMD_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .word_in (word),
      .shift   (shift_en),
      .msb     (msb),
      .last    (last)
   );

   ccw_cs_drive #(
      .NUM_CS        (NUM_CS),
      .CS_ACTIVE_LOW (CS_ACTIVE_LOW)
   ) u_cs (
      .sel    (mask_q),
      .enable (cs_en),
      .cs     (ctl_cs)
   );

   assign req_ready = (phase_q == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign load      = accept && req_ok;
   assign run       = phase_is_busy(phase_q);
   assign shift_en  = (phase_q == PH_HIGH) && tick && !last;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE: if (accept) phase_d = req_ok ? PH_PREP : PH_ERR;
         PH_PREP: if (tick) phase_d = PH_LOW;
         PH_LOW:  if (tick) phase_d = PH_HIGH;
         PH_HIGH: if (tick) phase_d = last ? PH_TAIL : PH_LOW;
         PH_TAIL: if (tick) phase_d = PH_REL;
         PH_REL:  if (tick) phase_d = PH_DONE;
         PH_DONE: phase_d = PH_IDLE;
         PH_ERR:  phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         mask_q  <= '0;
      end else begin
         phase_q <= phase_d;
         if (load) begin
            mask_q <= sel_mask;
         end
      end
   end

   assign lines_idle = phase_lines_idle(phase_q);
   assign cs_en      = (phase_q == PH_LOW) || (phase_q == PH_HIGH) ||
                       (phase_q == PH_TAIL);
   assign ctl_clk    = lines_idle || (phase_q == PH_HIGH);
   assign ctl_data   = lines_idle ? 1'b1 :
                       (phase_q == PH_PREP) ? 1'b0 : msb;
   assign busy       = run;
   assign done       = (phase_q == PH_DONE);
   assign err        = (phase_q == PH_ERR);

endmodule

// File: rtl/codec_ctl_writer_chk.sv
module codec_ctl_writer_chk #(
   parameter int NUM_CS        = 3,
   parameter int HALF_DIV      = 4,
   parameter bit CS_ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              ctl_clk,
   input logic              ctl_data,
   input logic [NUM_CS-1:0] ctl_cs
);

   logic        cs_any;
   logic [31:0] hi_cnt;

   assign cs_any = CS_ACTIVE_LOW ? (ctl_cs != {NUM_CS{1'b1}}) :
                                   (ctl_cs != {NUM_CS{1'b0}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
      end else if (!ctl_clk) begin
         hi_cnt <= '0;
      end else if (hi_cnt != 32'hFFFF_FFFF) begin
         hi_cnt <= hi_cnt + 32'd1;
      end
   end

   assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_clk && cs_any) |-> $stable(ctl_data));

   assert_select_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_any) |-> (!ctl_clk && $past(!ctl_clk) && $past(!ctl_data)));

   assert_release_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_any) |-> !ctl_clk);

   assert_half_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl_clk) && cs_any) |-> (hi_cnt == 32'(HALF_DIV)));

   assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !cs_any && ctl_clk && ctl_data && $past(req_valid)));

   assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!busy && !done && !err));

   assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ctl_clk && ctl_data && !cs_any && !busy));

endmodule

bind codec_ctl_writer codec_ctl_writer_chk #(
   .NUM_CS        (NUM_CS),
   .HALF_DIV      (HALF_DIV),
   .CS_ACTIVE_LOW (CS_ACTIVE_LOW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .ctl_clk   (ctl_clk),
   .ctl_data  (ctl_data),
   .ctl_cs    (ctl_cs)
);

// File: tb/tb_codec_ctl_writer.sv
module tb_codec_ctl_writer;

   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [3:0] req_mask = '0;
   logic [4:0] req_index = '0;
   logic [7:0] req_data = '0;
   logic       busy, done, err, ctl_clk, ctl_data;
   logic [2:0] ctl_cs;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit model_on = 1'b0;

   typedef struct packed {
      logic       ck;
      logic       dt;
      logic [2:0] cs;
      logic       bz;
      logic       dn;
      logic       er;
      logic       rd;
   } exp_t;

   exp_t expq[$];

   logic [15:0] cap = '0;
   int          nbits = 0;
   logic        prev_clk = 1'b1;

   always #10 clk = ~clk;

   codec_ctl_writer #(.HALF_DIV(DIV)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_mask  (req_mask),
      .req_index (req_index),
      .req_data  (req_data),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .ctl_clk   (ctl_clk),
      .ctl_data  (ctl_data),
      .ctl_cs    (ctl_cs)
   );

   task automatic check(string tag, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic exp_t mk(logic ck, logic dt, logic [2:0] cs, logic bz,
                               logic dn, logic er, logic rd);
      exp_t e;
      e.ck = ck; e.dt = dt; e.cs = cs; e.bz = bz; e.dn = dn; e.er = er; e.rd = rd;
      return e;
   endfunction

   task automatic push_n(exp_t e, int n);
      for (int k = 0; k < n; k++) expq.push_back(e);
   endtask

   // behavioural model of one accepted request, one entry per following cycle
   task automatic model_request(logic [3:0] m, logic [4:0] ix, logic [7:0] d);
      logic [15:0] w;
      logic [2:0]  on;
      if (m > 4'd7 || ix > 5'd7) begin
         expq.push_back(mk(1, 1, 3'b111, 0, 0, 1, 0));
      end else begin
         w  = {2'b10, 1'b1, ix, d};
         on = ~m[2:0];
         push_n(mk(0, 0, 3'b111, 1, 0, 0, 0), DIV);
         for (int b = 15; b >= 0; b--) begin
            push_n(mk(0, w[b], on, 1, 0, 0, 0), DIV);
            push_n(mk(1, w[b], on, 1, 0, 0, 0), DIV);
         end
         push_n(mk(0, w[0], on, 1, 0, 0, 0), DIV);
         push_n(mk(0, w[0], 3'b111, 1, 0, 0, 0), DIV);
         expq.push_back(mk(1, 1, 3'b111, 0, 1, 0, 0));
      end
   endtask

   always @(posedge clk) begin
      bit was_idle;
      if (model_on) begin
         was_idle = (expq.size() == 0);
         if (!was_idle) void'(expq.pop_front());
         if (was_idle && req_valid) model_request(req_mask, req_index, req_data);
      end
   end

   always @(negedge clk) begin
      exp_t e;
      if (model_on) begin
         e = (expq.size() != 0) ? expq[0] : mk(1, 1, 3'b111, 0, 0, 0, 1);
         check("R8 ctl_clk per cycle",       ctl_clk,   e.ck);
         check("R4 ctl_data per cycle",      ctl_data,  e.dt);
         check("R5 ctl_cs per cycle",        ctl_cs,    e.cs);
         check("R9 busy per cycle",          busy,      e.bz);
         check("R10 done per cycle",         done,      e.dn);
         check("R6 err per cycle",           err,       e.er);
         check("R9 req_ready per cycle",     req_ready, e.rd);
      end
      if (ctl_clk && !prev_clk && ctl_cs != 3'b111) begin
         cap = {cap[14:0], ctl_data};
         nbits++;
      end
      prev_clk = ctl_clk;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // raise a request and hold it until the edge that takes it
   task automatic issue(logic [3:0] m, logic [4:0] ix, logic [7:0] d);
      req_mask = m; req_index = ix; req_data = d; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      nbits = 0; cap = '0;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_ok(logic [4:0] ix, logic [7:0] d, logic chk_word);
      int n = 0;
      while (!done && n < 1000) begin
         @(negedge clk);
         n++;
      end
      check("R10 done reached", done, 1);
      check("R7 lines idle at done", {ctl_clk, ctl_data, ctl_cs}, 5'b11111);
      if (chk_word) begin
         check("R3 bit count", nbits, 16);
         check("R2 command word", cap, {2'b10, 1'b1, ix, d});
      end
      @(negedge clk);
      check("R10 ready after done", req_ready, 1);
   endtask

   task automatic frame(logic [3:0] m, logic [4:0] ix, logic [7:0] d);
      issue(m, ix, d);
      finish_ok(ix, d, m != 4'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic refused(logic [3:0] m, logic [4:0] ix, logic [7:0] d);
      issue(m, ix, d);
      check("R6 err pulse", err, 1);
      check("R6 no busy", busy, 0);
      check("R6 no select", ctl_cs, 3'b111);
      @(negedge clk);
      check("R6 err one cycle", err, 0);
      check("R6 no bits sent", nbits, 0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset clk/data", {ctl_clk, ctl_data}, 2'b11);
      check("R1 reset cs", ctl_cs, 3'b111);
      check("R1 reset flags", {busy, done, err}, 3'b000);
      check("R1 reset ready", req_ready, 1);
      rst_n = 1'b1;
      model_on = 1'b1;
      repeat (2) @(negedge clk);

      frame(4'b0111, 5'd0, 8'h00);
      frame(4'b0001, 5'd7, 8'hFF);
      frame(4'b0010, 5'd5, 8'h5A);
      refused(4'b1000, 5'd2, 8'h11);
      refused(4'b0011, 5'd8, 8'h22);
      frame(4'b0100, 5'd3, 8'h81);
      frame(4'b0000, 5'd1, 8'hC3);

      // R9: request held while a frame is in progress waits for idle
      req_mask = 4'b0101; req_index = 5'd6; req_data = 8'h3C; req_valid = 1'b1;
      @(negedge clk);
      check("R9 busy after accept", busy, 1);
      issue(4'b0011, 5'd2, 8'hA5);
      finish_ok(5'd2, 8'hA5, 1'b1);
      repeat (3) @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule